// File: doc/BRIEF.md
# Critical-Word-First Line Refill Sequencer

This block refills one cache line from a slower memory after a miss. It takes the line address and the word that missed, and asks memory for that word first. It then walks forward through the line, wrapping from the top word back to word zero, until every word has been fetched. Each returning word is written straight into a line-buffer write port. In the cycle the critical word is written, the block raises a one-cycle restart strobe, so a stalled requester can take that word from the write-data bus and carry on.

While a fill is in progress, the block keeps a bitmap of the words that have already landed. A probe port reports whether a new access to the line being filled can be served from that partial fill, or whether it has to wait. The line is reported as complete, and its address is offered for committing, only when the last of the sixteen words has been written. After that the block goes back to idle.

Memory is driven one word at a time through a request channel and a response channel, each with a valid/ready handshake. Only one request is ever in flight.

Top module: `line_refill_seq`

## Requirements
- R1: A miss is accepted only when `miss_ready` is high, and `miss_ready` is high exactly when no fill is running. The first memory request issued after an accepted miss carries the address {`miss_line`, `miss_word`}, with the word index in the low 4 bits of `mem_req_addr`.
- R2: Each fill issues exactly 16 word requests. Every request after the first targets the previous word index plus one, modulo 16, so the last request is for the word just before the critical word.
- R3: `early_restart` pulses exactly once per fill. It is high in the same cycle as the `buf_we` that writes the critical word, and that is the first write of the fill.
- R4: Each response handshake (`mem_rsp_valid` and `mem_rsp_ready` both high) drives `buf_we` high in that same cycle. In that cycle `buf_widx` is the word index that was requested and `buf_wdata` equals `mem_rsp_data`.
- R5: While a fill is running, a probe with `probe_line` equal to the filling line gives `probe_hit` if the word was written in an earlier cycle of this fill, and `probe_wait` otherwise. A probe of any other line, or any probe while idle, gives neither output.
- R6: At most one word request is outstanding at a time. No new request is raised until the response to the previous one has been taken. A request held off by a low `mem_req_ready` keeps `mem_req_valid` high and keeps its address unchanged.
- R7: `fill_done` pulses exactly once per fill, together with the 16th `buf_we`. In that cycle `fill_line` equals the accepted line address. In the next cycle `busy` is low.
- R8: A `miss_valid` raised while a fill is running is ignored. `miss_ready` stays low, the running fill completes with its original line and order, and no further request follows the fill.
- R9: After reset, `busy`, `mem_req_valid`, `buf_we`, `early_restart` and `fill_done` are low and `miss_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Block is idle and will accept a miss |
| miss_line | input | LINE_ADDR_W | Line address of the miss |
| miss_word | input | IW (4) | Word that missed within the line |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | LINE_ADDR_W+IW | Word address {line, word} |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block takes the read data |
| mem_rsp_data | input | DATA_W | Read data |
| buf_we | output | 1 | Line-buffer write enable |
| buf_widx | output | IW (4) | Line-buffer word index |
| buf_wdata | output | DATA_W | Line-buffer write data |
| early_restart | output | 1 | Critical word is on `buf_wdata` this cycle |
| fill_done | output | 1 | Last word written; line may be committed |
| fill_line | output | LINE_ADDR_W | Line address being filled |
| busy | output | 1 | Fill in progress |
| probe_line | input | LINE_ADDR_W | Line address of a probing access |
| probe_word | input | IW (4) | Word index of a probing access |
| probe_hit | output | 1 | Probed word is already in the partial line |
| probe_wait | output | 1 | Probed word belongs to the fill but has not arrived |

## Verification
The assertions assume that memory follows the channel rules. A response only ever answers a request that was accepted, it comes back in request order, and it is held until taken. Under those rules, the order, hold and restart properties rest on the block's own behaviour. The bench's memory model keeps to this contract. It raises `mem_rsp_valid` only after latching an accepted request, drops it only after a completed handshake, and adds programmable latency and a periodic `mem_req_ready` stall. Misses are driven only at idle, except in the scenario that deliberately offers one during a fill.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_AWAIT = 2'd2
  } fill_state_t;
endpackage

// File: rtl/refill_rst_sync.sv
module refill_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/refill_wrap_ctr.sv
module refill_wrap_ctr #(
  parameter int WORDS = 16,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] load_idx,
  input  logic          step,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] crit,
  output logic          first,
  output logic          last
);
  localparam logic [IW-1:0] TOP_IDX = IW'(WORDS - 1);
  localparam bit POW2 = ((WORDS & (WORDS - 1)) == 0);

  logic [IW-1:0] idx_q, idx_d, crit_q, crit_d, cnt_q, cnt_d, idx_inc;
  logic          ctr_en;

  generate
    if (POW2) begin : g_pow2
      assign idx_inc = idx_q + 1'b1;
    end else begin : g_cmp
      assign idx_inc = (idx_q == TOP_IDX) ? '0 : idx_q + 1'b1;
    end
  endgenerate

  assign ctr_en = load | step;

  always_comb begin
    idx_d  = idx_q;
    crit_d = crit_q;
    cnt_d  = cnt_q;
    if (load) begin
      idx_d  = load_idx;
      crit_d = load_idx;
      cnt_d  = '0;
    end else if (step) begin
      idx_d  = idx_inc;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      crit_q <= '0;
      cnt_q  <= '0;
    end else if (ctr_en) begin
      idx_q  <= idx_d;
      crit_q <= crit_d;
      cnt_q  <= cnt_d;
    end
  end

  assign idx   = idx_q;
  assign crit  = crit_q;
  assign first = (cnt_q == '0);
  assign last  = (cnt_q == TOP_IDX);
endmodule

// File: rtl/refill_arrival_map.sv
module refill_arrival_map #(
  parameter int WORDS = 16,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set,
  input  logic [IW-1:0] set_idx,
  input  logic [IW-1:0] q_idx,
  output logic          q_hit
);
  logic [WORDS-1:0] map_q;

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_bit
      logic bit_en;
      assign bit_en = clr | (set && (set_idx == IW'(g)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      map_q[g] <= 1'b0;
        else if (bit_en) map_q[g] <= ~clr;
      end
    end
  endgenerate

  assign q_hit = map_q[q_idx];
endmodule

// File: rtl/refill_fsm.sv
module refill_fsm
  import refill_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic last_word,
  output logic idle,
  output logic accept,
  output logic req_valid,
  output logic rsp_ready,
  output logic rsp_fire
);
  fill_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (miss_valid) state_d = ST_ISSUE;
      ST_ISSUE: if (req_ready)  state_d = ST_AWAIT;
      ST_AWAIT: if (rsp_valid)  state_d = last_word ? ST_IDLE : ST_ISSUE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle & miss_valid;
  assign req_valid = (state_q == ST_ISSUE);
  assign rsp_ready = (state_q == ST_AWAIT);
  assign rsp_fire  = rsp_ready & rsp_valid;
endmodule

// File: rtl/line_refill_seq.sv
module line_refill_seq #(
  parameter  int LINE_WORDS  = 16,
  parameter  int DATA_W      = 32,
  parameter  int LINE_ADDR_W = 26,
  localparam int IW          = $clog2(LINE_WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      miss_valid,
  output logic                      miss_ready,
  input  logic [LINE_ADDR_W-1:0]    miss_line,
  input  logic [IW-1:0]             miss_word,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [LINE_ADDR_W+IW-1:0] mem_req_addr,
  input  logic                      mem_rsp_valid,
  output logic                      mem_rsp_ready,
  input  logic [DATA_W-1:0]         mem_rsp_data,
  output logic                      buf_we,
  output logic [IW-1:0]             buf_widx,
  output logic [DATA_W-1:0]         buf_wdata,
  output logic                      early_restart,
  output logic                      fill_done,
  output logic [LINE_ADDR_W-1:0]    fill_line,
  output logic                      busy,
  input  logic [LINE_ADDR_W-1:0]    probe_line,
  input  logic [IW-1:0]             probe_word,
  output logic                      probe_hit,
  output logic                      probe_wait
);
  logic                   rst_sync_n;
  logic                   idle, accept, rsp_fire;
  logic                   first_word, last_word, word_here, line_match;
  logic [IW-1:0]          cur_idx, crit_idx;
  logic [LINE_ADDR_W-1:0] line_q;

  refill_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  refill_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .miss_valid (miss_valid),
    .req_ready  (mem_req_ready),
    .rsp_valid  (mem_rsp_valid),
    .last_word  (last_word),
    .idle       (idle),
    .accept     (accept),
    .req_valid  (mem_req_valid),
    .rsp_ready  (mem_rsp_ready),
    .rsp_fire   (rsp_fire)
  );

  refill_wrap_ctr #(.WORDS(LINE_WORDS), .IW(IW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (accept),
    .load_idx (miss_word),
    .step     (rsp_fire),
    .idx      (cur_idx),
    .crit     (crit_idx),
    .first    (first_word),
    .last     (last_word)
  );

  refill_arrival_map #(.WORDS(LINE_WORDS), .IW(IW)) u_map (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (accept),
    .set     (rsp_fire),
    .set_idx (cur_idx),
    .q_idx   (probe_word),
    .q_hit   (word_here)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  line_q <= '0;
    else if (accept)  line_q <= miss_line;
  end

  assign miss_ready    = idle;
  assign busy          = ~idle;
  assign mem_req_addr  = {line_q, cur_idx};
  assign buf_we        = rsp_fire;
  assign buf_widx      = cur_idx;
  assign buf_wdata     = mem_rsp_data;
  assign early_restart = rsp_fire & first_word;
  assign fill_done     = rsp_fire & last_word;
  assign fill_line     = line_q;
  assign line_match    = busy & (probe_line == line_q);
  assign probe_hit     = line_match & word_here;
  assign probe_wait    = line_match & ~word_here;
endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
  parameter int LINE_WORDS  = 16,
  parameter int LINE_ADDR_W = 26,
  parameter int IW          = $clog2(LINE_WORDS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      miss_valid,
  input logic                      miss_ready,
  input logic [LINE_ADDR_W-1:0]    miss_line,
  input logic [IW-1:0]             miss_word,
  input logic                      mem_req_valid,
  input logic                      mem_req_ready,
  input logic [LINE_ADDR_W+IW-1:0] mem_req_addr,
  input logic                      buf_we,
  input logic [IW-1:0]             buf_widx,
  input logic                      early_restart,
  input logic                      fill_done,
  input logic                      busy,
  input logic                      probe_hit,
  input logic                      probe_wait,
  input logic [IW-1:0]             crit_idx
);
  function automatic logic [IW-1:0] wrap_next(input logic [IW-1:0] w);
    return (w == IW'(LINE_WORDS - 1)) ? '0 : w + 1'b1;
  endfunction

  assert_first_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (mem_req_valid
      && mem_req_addr[IW-1:0] == $past(miss_word)
      && mem_req_addr[LINE_ADDR_W+IW-1:IW] == $past(miss_line)));

  assert_wrap_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && !fill_done) |=> (mem_req_valid
      && mem_req_addr[IW-1:0] == wrap_next($past(buf_widx))));

  assert_restart_critical_R3: assert property (@(posedge clk) disable iff (!rst_n)
    early_restart |-> (buf_we && buf_widx == crit_idx));

  assert_probe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(probe_hit && probe_wait));

  assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  assert_request_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_done_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (!busy && miss_ready));

  assert_busy_blocks_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !miss_ready);
endmodule

bind line_refill_seq refill_checker #(
  .LINE_WORDS  (LINE_WORDS),
  .LINE_ADDR_W (LINE_ADDR_W),
  .IW          (IW)
) u_refill_checker (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .miss_line     (miss_line),
  .miss_word     (miss_word),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .buf_we        (buf_we),
  .buf_widx      (buf_widx),
  .early_restart (early_restart),
  .fill_done     (fill_done),
  .busy          (busy),
  .probe_hit     (probe_hit),
  .probe_wait    (probe_wait),
  .crit_idx      (crit_idx)
);

// File: tb/test_line_refill_seq.sv
module test_line_refill_seq;
  localparam int LA = 26;
  localparam int IW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic          miss_ready;
  logic [LA-1:0] miss_line = '0;
  logic [IW-1:0] miss_word = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [LA+IW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_ready;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          buf_we;
  logic [IW-1:0] buf_widx;
  logic [DW-1:0] buf_wdata;
  logic          early_restart, fill_done, busy, probe_hit, probe_wait;
  logic [LA-1:0] fill_line;
  logic [LA-1:0] probe_line = '0;
  logic [IW-1:0] probe_word = '0;

  line_refill_seq i_line_refill_seq (.*);

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;

  // memory model settings and logs
  int lat = 0;
  bit stall = 1'b0;
  int cyc = 0;
  bit fire_req = 1'b0, fire_rsp = 1'b0, pend = 1'b0, held = 1'b0;
  logic [LA+IW-1:0] addr_next, paddr, held_addr;
  int dly = 0;
  int req_cnt = 0, wr_cnt = 0, rst_cnt = 0, rst_pos = -1, done_cnt = 0, done_pos = -1;
  int outst = 0, proto_err = 0;
  logic [IW-1:0] req_log [16];
  logic [IW-1:0] wr_idx [16];
  logic [DW-1:0] wr_data [16];
  logic [LA-1:0] done_line;

  function automatic logic [DW-1:0] mdata(input logic [LA+IW-1:0] a);
    return {2'b10, a} ^ 32'h0F0F_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    req_cnt = 0; wr_cnt = 0; rst_cnt = 0; rst_pos = -1;
    done_cnt = 0; done_pos = -1; proto_err = 0;
  endtask

  // memory responder and write monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (fire_rsp) mem_rsp_valid = 1'b0;
      if (fire_req) begin pend = 1'b1; paddr = addr_next; dly = lat; end
      if (pend && !mem_rsp_valid) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = mdata(paddr); pend = 1'b0;
        end else dly--;
      end
      mem_req_ready = stall ? (cyc % 3 == 2) : 1'b1;
      #1;
      if (held && !(mem_req_valid && mem_req_addr == held_addr)) proto_err++;
      held = mem_req_valid && !mem_req_ready;
      held_addr = mem_req_addr;
      fire_req = mem_req_valid && mem_req_ready;
      fire_rsp = mem_rsp_valid && mem_rsp_ready;
      addr_next = mem_req_addr;
      if (fire_req) begin
        if (outst != 0) proto_err++;
        outst++;
        if (req_cnt < 16) req_log[req_cnt] = mem_req_addr[IW-1:0];
        req_cnt++;
      end
      if (fire_rsp) outst--;
      if (buf_we) begin
        if (!fire_rsp) proto_err++;
        if (wr_cnt < 16) begin wr_idx[wr_cnt] = buf_widx; wr_data[wr_cnt] = buf_wdata; end
        if (buf_wdata != mem_rsp_data) proto_err++;
        if (early_restart) begin rst_cnt++; rst_pos = wr_cnt; end
        if (fill_done) begin done_cnt++; done_pos = wr_cnt; done_line = fill_line; end
        wr_cnt++;
      end else if (early_restart || fill_done) proto_err++;
    end
  end

  task automatic start_miss(input logic [LA-1:0] line, input logic [IW-1:0] w);
    @(negedge clk);
    miss_line = line; miss_word = w; miss_valid = 1'b1;
    #2;
    chk(miss_ready == 1'b1, "R1 miss_ready when idle", miss_ready, 1);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (done_cnt == 0) @(negedge clk);
    #2;
  endtask

  task automatic check_fill(input logic [LA-1:0] line, input logic [IW-1:0] crit);
    bit ord_ok = 1'b1, wr_ok = 1'b1;
    logic [IW-1:0] e;
    for (int k = 0; k < 16; k++) begin
      e = crit + IW'(k);
      if (k == 0 && req_log[k] != crit) ord_ok = 1'b0;
      if (req_log[k] != e) ord_ok = 1'b0;
      if (wr_idx[k] != e || wr_data[k] != mdata({line, e})) wr_ok = 1'b0;
    end
    chk(req_cnt == 16 && ord_ok, "R2 wrap order / 16 requests", req_cnt, 16);
    chk(wr_ok && wr_cnt == 16, "R4 buffer writes index/data", wr_cnt, 16);
    chk(rst_cnt == 1 && rst_pos == 0, "R3 early restart on critical word", rst_pos, 0);
    chk(done_cnt == 1 && done_pos == 15, "R7 done with 16th write", done_pos, 15);
    chk(done_line == line, "R7 fill_line at done", done_line, line);
    chk(busy == 1'b0, "R7 idle after done", busy, 0);
    chk(proto_err == 0 && outst == 0, "R6 single outstanding / held request", proto_err, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_req_valid == 0 && buf_we == 0 && early_restart == 0 && fill_done == 0,
        "R9 outputs idle in reset", {busy, mem_req_valid, buf_we, early_restart, fill_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(miss_ready == 1'b1 && busy == 1'b0, "R9 ready after reset", miss_ready, 1);
  endtask

  task automatic t_fill(input logic [LA-1:0] line, input logic [IW-1:0] crit, input int l, input bit st);
    lat = l; stall = st;
    clear_logs();
    start_miss(line, crit);
    wait_done();
    check_fill(line, crit);
    stall = 1'b0;
  endtask

  task automatic probe(input logic [LA-1:0] line, input logic [IW-1:0] w,
                       input bit eh, input bit ew, input string msg);
    probe_line = line; probe_word = w;
    #1;
    chk(probe_hit == eh && probe_wait == ew, msg, {probe_hit, probe_wait}, {eh, ew});
  endtask

  task automatic t_probe();
    logic [LA-1:0] L = 26'h12_3456;
    lat = 6; stall = 1'b0;
    clear_logs();
    start_miss(L, 4'd9);
    while (wr_cnt < 1) @(negedge clk);
    @(negedge clk);
    probe(L, 4'd9, 1, 0, "R5 arrived critical word hits");
    probe(L, 4'd10, 0, 1, "R5 pending word waits");
    probe(L, 4'd1, 0, 1, "R5 wrapped word waits");
    probe(L + 1, 4'd9, 0, 0, "R5 other line neither");
    while (wr_cnt < 3) @(negedge clk);
    @(negedge clk);
    probe(L, 4'd11, 1, 0, "R5 third word hits");
    probe(L, 4'd12, 0, 1, "R5 fourth word waits");
    wait_done();
    check_fill(L, 4'd9);
    @(negedge clk);
    probe(L, 4'd9, 0, 0, "R5 idle probe neither");
  endtask

  task automatic t_busy_miss();
    logic [LA-1:0] A = 26'h0AB_CDE;
    lat = 2; stall = 1'b0;
    clear_logs();
    start_miss(A, 4'd3);
    while (wr_cnt < 2) @(negedge clk);
    miss_line = 26'h1FF_FFFF; miss_word = 4'd7; miss_valid = 1'b1;
    #2;
    chk(miss_ready == 1'b0, "R8 miss_ready low while busy", miss_ready, 0);
    @(negedge clk);
    miss_valid = 1'b0;
    wait_done();
    check_fill(A, 4'd3);
    repeat (4) @(negedge clk);
    chk(req_cnt == 16 && mem_req_valid == 0, "R8 ignored miss issued nothing", req_cnt, 16);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fill(26'h000_0040, 4'd0, 0, 1'b0);
    t_fill(26'h2AA_5555, 4'd5, 3, 1'b0);
    t_fill(26'h3FF_FFFF, 4'd15, 1, 1'b1);
    t_fill(26'h001_2345, 4'd8, 0, 1'b1);
    t_probe();
    t_busy_miss();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule